// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects eight maskable interrupt sources and picks the one with the highest fixed priority among those that are pending and enabled. It gives the CPU that source's pair of vector-table addresses. A rising edge on a source pin is synchronized and latched into a request flag. The flag stays set until the CPU acknowledges that interrupt or software clears it. Software can also set flags to raise interrupts itself. A global mask input gates every maskable source. Each source also has its own enable bit.

The CPU sees `irq_o` as a valid signal and `irq_ack_i` as a single-cycle ready pulse. Once `irq_o` is high, the selected source and its vectors are held until the CPU acknowledges it, or until that source stops being eligible. A newly pending request of higher priority does not replace the held selection. An acknowledge clears the accepted flag, and at the same clock edge the next winner is selected. Two override inputs take the vector outputs ahead of any maskable source. The first requests the reset vector and cannot be masked. The second requests the software-break vector.

Top module: `irqc_top`

## Requirements
- R1: After reset, all four registers read 0x00 and `irq_o` is low.
- R2: A rising edge on `src_i[k]` sets request flag k at the third rising clock edge after the pin rises. A pin that stays high does not set the flag again after software clears it.
- R3: The request registers sit at byte address 0x00CF (high) and 0x00CD (low). High bits 7..2 hold sources 0..5, and low bits 7..6 hold sources 6 and 7. Writes store the value, so software can set and clear flags. Bits that map to no source read 0.
- R4: The enable registers sit at 0x00CE (high) and 0x00CC (low), use the same bit layout as the request registers, and read back what was written.
- R5: While `gie_i` is 0, `irq_o` is low one cycle later, whatever flags are pending.
- R6: A pending source whose enable bit is 0 never raises `irq_o`.
- R7: Priority is fixed, and source 0 is highest. The order is key scan 0, external 1, external 2, timer0 3, timer1 4, timer2 5, watchdog 6, interval timer 7.
- R8: The high vector for sources 0..7 is, in order, FFFB, FFF9, FFF7, FFF3, FFF1, FFEF, FFE9, FFE7. The low vector is always the high vector with bit 0 cleared.
- R9: An acknowledge while `irq_o` is high clears only the accepted source's flag. The next eligible source is presented one cycle later.
- R10: While `irq_o` is high, the held source and its vectors do not change until acknowledge, even if a higher-priority request appears. This holds as long as the held source stays eligible.
- R11: `rstvec_req_i` forces the vectors to FFFF/FFFE above everything else. Otherwise `brk_req_i` forces FFDF/FFDE.
- R12: When a synchronized edge and a software write of 0 to the same flag fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 8 | Interrupt source pins, index = priority (0 highest) |
| gie_i | input | 1 | Global maskable-interrupt enable |
| irq_ack_i | input | 1 | Single-cycle acknowledge from the CPU |
| brk_req_i | input | 1 | Selects the software-break vector |
| rstvec_req_i | input | 1 | Selects the reset vector, unmaskable |
| bus_addr_i | input | 16 | Register byte address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for `bus_addr_i` |
| irq_o | output | 1 | Maskable interrupt pending toward the CPU |
| vec_hi_o | output | 16 | High vector-table address |
| vec_lo_o | output | 16 | Low vector-table address |

## Verification
The hardest case to reach from the ports is a synchronized pin edge landing in the same clock cycle as a software write that clears the same flag. The synchronizer delay is three edges. The bench raises a pin just after a falling edge, counts two rising edges, and then issues the clearing write so that it commits on the third. The held-selection rule is reached by first presenting a low-priority source and then raising a higher one by software, with no acknowledge in between. Random rounds fill the enable and request registers with the global mask off, so that each round starts from a fresh selection.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC = 8;
  localparam int IDW  = $clog2(NSRC);
  localparam int AW   = 16;
  typedef logic [IDW-1:0] src_id_t;

  localparam logic [AW-1:0] A_EN_LO = 16'h00CC;
  localparam logic [AW-1:0] A_RQ_LO = 16'h00CD;
  localparam logic [AW-1:0] A_EN_HI = 16'h00CE;
  localparam logic [AW-1:0] A_RQ_HI = 16'h00CF;

  localparam logic [15:0] VEC_RST  = 16'hFFFF;
  localparam logic [15:0] VEC_BRK  = 16'hFFDF;
  localparam logic [15:0] VEC_NONE = 16'h0000;

  // Position of source i inside the 16-bit {high, low} register pair.
  function automatic logic [3:0] pos16(input int i);
    return (i < 6) ? 4'(15 - i) : 4'(13 - i);
  endfunction

  // High vector address of a maskable source.
  function automatic logic [15:0] vec_of(input src_id_t id);
    case (id)
      3'd0:    return 16'hFFFB;
      3'd1:    return 16'hFFF9;
      3'd2:    return 16'hFFF7;
      3'd3:    return 16'hFFF3;
      3'd4:    return 16'hFFF1;
      3'd5:    return 16'hFFEF;
      3'd6:    return 16'hFFE9;
      default: return 16'hFFE7;
    endcase
  endfunction
endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_sync
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= async_i[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise_o[g] = s2 & ~s3;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic [7:0]      wdata_i,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [7:0]      rdata_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] req_o
);
  logic [NSRC-1:0] en_q, req_q, en_n, req_n;
  logic [15:0]     en16, rq16;

  always_comb begin
    en_n  = en_q;
    req_n = req_q & ~clr_i;
    if (wr_i) begin
      for (int i = 0; i < NSRC; i++) begin
        if (addr_i == ((i < 6) ? A_EN_HI : A_EN_LO)) en_n[i]  = wdata_i[pos16(i) % 8];
        if (addr_i == ((i < 6) ? A_RQ_HI : A_RQ_LO)) req_n[i] = wdata_i[pos16(i) % 8];
      end
    end
    req_n = req_n | set_i;   // a hardware edge wins over any clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      req_q <= '0;
    end else begin
      en_q  <= en_n;
      req_q <= req_n;
    end
  end

  always_comb begin
    en16 = '0;
    rq16 = '0;
    for (int i = 0; i < NSRC; i++) begin
      en16[pos16(i)] = en_q[i];
      rq16[pos16(i)] = req_q[i];
    end
    case (addr_i)
      A_EN_LO: rdata_o = en16[7:0];
      A_RQ_LO: rdata_o = rq16[7:0];
      A_EN_HI: rdata_o = en16[15:8];
      A_RQ_HI: rdata_o = rq16[15:8];
      default: rdata_o = 8'h00;
    endcase
  end

  assign en_o  = en_q;
  assign req_o = req_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            gie_i,
  input  logic            ack_i,
  output logic            vld_o,
  output src_id_t         id_o,
  output logic [NSRC-1:0] elig_o,
  output logic [NSRC-1:0] clr_o
);
  logic [NSRC-1:0] elig, taken, elig_m;
  logic            cur_vld, any, load;
  src_id_t         cur_id, pick;

  assign elig   = req_i & en_i & {NSRC{gie_i}};
  assign taken  = (cur_vld && ack_i) ? ({{(NSRC-1){1'b0}}, 1'b1} << cur_id) : '0;
  assign elig_m = elig & ~taken;
  assign any    = |elig_m;
  assign load   = !cur_vld || ack_i || !elig[cur_id];

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_m[i]) pick = src_id_t'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_vld <= 1'b0;
      cur_id  <= '0;
    end else if (load) begin
      cur_vld <= any;
      cur_id  <= pick;
    end
  end

  assign vld_o  = cur_vld;
  assign id_o   = cur_id;
  assign elig_o = elig;
  assign clr_o  = taken;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    src_i,
  input  logic          gie_i,
  input  logic          irq_ack_i,
  input  logic          brk_req_i,
  input  logic          rstvec_req_i,
  input  logic [15:0]   bus_addr_i,
  input  logic          bus_wr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  output logic          irq_o,
  output logic [15:0]   vec_hi_o,
  output logic [15:0]   vec_lo_o
);
  logic [NSRC-1:0] set_p, clr_p, en_q, req_q, elig;
  src_id_t         sel_id;

  irqc_edge_sync #(.N(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_i), .rise_o(set_p)
  );

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .wdata_i(bus_wdata_i), .set_i(set_p), .clr_i(clr_p),
    .rdata_o(bus_rdata_o), .en_o(en_q), .req_o(req_q)
  );

  irqc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_q), .en_i(en_q), .gie_i(gie_i),
    .ack_i(irq_ack_i), .vld_o(irq_o), .id_o(sel_id), .elig_o(elig), .clr_o(clr_p)
  );

  always_comb begin
    if (rstvec_req_i)   vec_hi_o = VEC_RST;
    else if (brk_req_i) vec_hi_o = VEC_BRK;
    else if (irq_o)     vec_hi_o = vec_of(sel_id);
    else                vec_hi_o = VEC_NONE;
  end
  assign vec_lo_o = {vec_hi_o[15:1], 1'b0};
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            gie_i,
  input logic            irq_ack_i,
  input logic            brk_req_i,
  input logic            rstvec_req_i,
  input logic [15:0]     bus_addr_i,
  input logic            bus_wr_i,
  input logic [7:0]      bus_rdata_o,
  input logic            irq_o,
  input logic [15:0]     vec_hi_o,
  input src_id_t         sel_id,
  input logic [NSRC-1:0] elig,
  input logic [NSRC-1:0] req_q,
  input logic [NSRC-1:0] set_p
);
  p_mask_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !irq_o);

  p_rst_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rstvec_req_i |-> vec_hi_o == 16'hFFFF);

  p_brk_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req_i && !rstvec_req_i) |-> vec_hi_o == 16'hFFDF);

  p_unused_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == A_EN_LO || bus_addr_i == A_RQ_LO) |-> bus_rdata_o[5:0] == 6'd0);

  p_unused_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == A_EN_HI || bus_addr_i == A_RQ_HI) |-> bus_rdata_o[1:0] == 2'd0);

  p_hold_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i && elig[sel_id]) |=> (irq_o && $stable(sel_id)));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_ack_i && !bus_wr_i && !set_p[sel_id]) |=> !req_q[$past(sel_id)]);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_p) |=> ((req_q & $past(set_p)) == $past(set_p)));
endmodule

bind irqc_top irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .irq_ack_i(irq_ack_i),
  .brk_req_i(brk_req_i), .rstvec_req_i(rstvec_req_i), .bus_addr_i(bus_addr_i),
  .bus_wr_i(bus_wr_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
  .vec_hi_o(vec_hi_o), .sel_id(sel_id), .elig(elig), .req_q(req_q), .set_p(set_p)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_i = '0;
  logic        gie_i = 1'b0, irq_ack_i = 1'b0, brk_req_i = 1'b0, rstvec_req_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        irq_o;
  logic [15:0] vec_hi_o, vec_lo_o;

  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [15:0] EN_LO = 16'h00CC, RQ_LO = 16'h00CD, EN_HI = 16'h00CE, RQ_HI = 16'h00CF;

  always #10 clk = ~clk;

  irqc_top uut (.*);

  function automatic logic [15:0] exp_vec(input int k);
    case (k)
      0: return 16'hFFFB; 1: return 16'hFFF9; 2: return 16'hFFF7; 3: return 16'hFFF3;
      4: return 16'hFFF1; 5: return 16'hFFEF; 6: return 16'hFFE9; default: return 16'hFFE7;
    endcase
  endfunction

  function automatic logic [7:0] to_vec(input logic [7:0] hi, input logic [7:0] lo);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (i < 6) ? hi[7-i] : lo[13-i];
    return v;
  endfunction

  function automatic int top_of(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk); #1;
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack_i = 1'b1;
    @(posedge clk); #1;
    irq_ack_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d, eh, el, rh, rl, v;
    int k;
    void'($urandom(32'd1234));
    cyc(4);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(EN_LO, d); check("R1 en_lo", d, 8'h00);
    rd(RQ_LO, d); check("R1 rq_lo", d, 8'h00);
    rd(EN_HI, d); check("R1 en_hi", d, 8'h00);
    rd(RQ_HI, d); check("R1 rq_hi", d, 8'h00);
    check("R1 irq", irq_o, 1'b0);
    // R4 enable read back, R3 unused bits
    wr(EN_HI, 8'hA4); rd(EN_HI, d); check("R4 en_hi", d, 8'hA4);
    wr(EN_LO, 8'h40); rd(EN_LO, d); check("R4 en_lo", d, 8'h40);
    wr(EN_HI, 8'hFF); rd(EN_HI, d); check("R3 en_hi unused", d, 8'hFC);
    wr(RQ_HI, 8'hFF); rd(RQ_HI, d); check("R3 rq_hi unused", d, 8'hFC);
    wr(RQ_LO, 8'hFF); rd(RQ_LO, d); check("R3 rq_lo unused", d, 8'hC0);
    wr(RQ_HI, 8'h00); wr(RQ_LO, 8'h00);
    rd(RQ_HI, d); check("R3 sw clear", d, 8'h00);
    // R2 edge timing: timer0 (source 3) -> high bit 4
    bus_addr_i = RQ_HI;
    @(negedge clk) src_i[3] = 1'b1;
    cyc(2); check("R2 not yet", bus_rdata_o, 8'h00);
    cyc(1); check("R2 set at 3rd edge", bus_rdata_o, 8'h10);
    wr(RQ_HI, 8'h00); cyc(6);
    rd(RQ_HI, d); check("R2 level no retrigger", d, 8'h00);
    @(negedge clk) src_i[3] = 1'b0;
    cyc(4);
    // R12 collision: pin edge and software clear commit on the same edge
    @(negedge clk) src_i[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    wr(RQ_HI, 8'h00);
    rd(RQ_HI, d); check("R12 set wins", d, 8'h80);
    wr(RQ_HI, 8'h00);
    @(negedge clk) src_i[0] = 1'b0;
    cyc(4);
    // R6 enable gating
    wr(EN_HI, 8'h00); wr(EN_LO, 8'h00);
    wr(RQ_HI, 8'hFC); wr(RQ_LO, 8'hC0);
    @(negedge clk) gie_i = 1'b1;
    cyc(3); check("R6 disabled no irq", irq_o, 1'b0);
    // R5 global mask
    @(negedge clk) gie_i = 1'b0;
    wr(EN_HI, 8'hFC); wr(EN_LO, 8'hC0);
    cyc(3); check("R5 mask off", irq_o, 1'b0);
    // R7 R8 R9: all pending, drain by acknowledges
    @(negedge clk) gie_i = 1'b1;
    cyc(2);
    for (int i = 0; i < 8; i++) begin
      check("R7 irq high", irq_o, 1'b1);
      check("R8 vec_hi", vec_hi_o, exp_vec(i));
      check("R8 vec_lo", vec_lo_o, exp_vec(i) & 16'hFFFE);
      ack();
      if (i == 0) begin
        rd(RQ_HI, d); check("R9 only accepted cleared", d, 8'h7C);
      end
    end
    check("R9 drained", irq_o, 1'b0);
    rd(RQ_LO, d); check("R9 low flags cleared", d, 8'h00);
    // R10 held selection
    wr(RQ_HI, 8'h04); cyc(1);
    check("R10 first", vec_hi_o, 16'hFFEF);
    wr(RQ_HI, 8'h84); cyc(2);
    check("R10 held", vec_hi_o, 16'hFFEF);
    // R11 overrides
    @(negedge clk) brk_req_i = 1'b1;
    #1 check("R11 brk", vec_hi_o, 16'hFFDF); check("R11 brk lo", vec_lo_o, 16'hFFDE);
    @(negedge clk) rstvec_req_i = 1'b1;
    #1 check("R11 rst", vec_hi_o, 16'hFFFF); check("R11 rst lo", vec_lo_o, 16'hFFFE);
    @(negedge clk) begin brk_req_i = 1'b0; rstvec_req_i = 1'b0; end
    ack();
    check("R10 after ack", vec_hi_o, 16'hFFFB);
    ack(); cyc(1);
    // Random rounds
    for (int r = 0; r < 40; r++) begin
      @(negedge clk) gie_i = 1'b0;
      cyc(2);
      eh = 8'($urandom) & 8'hFC; el = 8'($urandom) & 8'hC0;
      rh = 8'($urandom) & 8'hFC; rl = 8'($urandom) & 8'hC0;
      wr(EN_HI, eh); wr(EN_LO, el); wr(RQ_HI, rh); wr(RQ_LO, rl);
      @(negedge clk) gie_i = 1'b1;
      cyc(2);
      v = to_vec(eh, el) & to_vec(rh, rl);
      k = top_of(v);
      check("R7 rand irq", irq_o, (k >= 0));
      if (k >= 0) begin
        check("R8 rand vec", vec_hi_o, exp_vec(k));
        ack();
        v[k] = 1'b0;
        k = top_of(v);
        check("R9 rand next irq", irq_o, (k >= 0));
        if (k >= 0) check("R9 rand next vec", vec_hi_o, exp_vec(k));
      end
    end
    done = 1;
    finish_run();
  end
endmodule